// File: doc/BRIEF.md
# Indexed Page Bank Mapper

This block translates CPU memory accesses that fall inside the upper expansion window (byte addresses 0x80000 through 0xEFFFF) into a large physical space built from 16 KB pages. Each page of the window has its own programmable 16-bit bank register. The low 15 bits of that register give the physical page number. Accesses below the window, and accesses to the ROM area above it, are passed through untouched and reported as unmapped.

Software programs the mapper through two I/O words. The first is an 8-bit index register. The second is a bank data port, which reads or writes the bank entry named by bits 6..2 of the index. Two entries overlay the colour-graphics framebuffer and are refused. Entries past the end of the register file are also refused. Each refusal produces its own one-cycle pulse.

The translation path is a three-state machine: `XS_IDLE`, `XS_MAPPED` and `XS_BYPASS`. From any state, a cycle without a request goes to `XS_IDLE`. A request inside the window goes to `XS_MAPPED`. A request outside the window goes to `XS_BYPASS`. The outputs are decoded from the state, so every result appears one clock after its request.

The write path classifies each bank data write as one of four outcomes:

- `WO_NONE`: no bank write this cycle.
- `WO_STORE`: the write is stored.
- `WO_RANGE`: the selected entry is 28 or above, so the write is dropped and `range_err` pulses.
- `WO_RSV`: the selected entry is 10 or 11, so the write is dropped and `fb_flag` pulses.

Top module: `ems_bank_mapper`

## Requirements
- R1: After reset, the index register and all 28 bank entries read back as zero. `xl_valid`, `range_err` and `fb_flag` are low.
- R2: A write with `io_sel`=0 and `io_be[0]`=1 loads `io_wdata[7:0]` into the 8-bit index register. A read with `io_sel`=0 returns the index in bits 7..0 and zero in bits 15..8. An index write with `io_be[0]`=0 leaves the index unchanged.
- R3: With `io_sel`=1, the bank data port reads and writes entry (index >> 2) & 0x1F. Bits 1..0 and bit 7 of the index play no part in the selection.
- R4: Bank data writes honour byte lanes. `io_be[0]` enables bits 7..0 and `io_be[1]` enables bits 15..8, and a disabled lane keeps its old value.
- R5: A bank data write whose selected entry is 28 or above stores nothing, so no entry changes. It raises `range_err` for exactly the one cycle after the write, and a read of that entry returns zero.
- R6: A bank data write to entry 10 or 11 stores nothing. It raises `fb_flag` for exactly the one cycle after the write.
- R7: A request with a word address in 0x40000..0x77FFF gives, one cycle later, `xl_valid`=1 and `xl_mapped`=1. The offset is address bits 12..0. The page is bits 14..0 of the entry selected by address bits 17..13.
- R8: The page number is masked to 15 bits, so bit 15 of a bank entry never reaches `xl_page`.
- R9: A request outside the window gives, one cycle later, `xl_valid`=1 and `xl_mapped`=0, with page and offset at zero.
- R10: A cycle with no request gives `xl_valid`=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_sel | input | 1 | 0 selects the index register, 1 selects the bank data port |
| io_be | input | 2 | Byte lane enables for I/O writes |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data for the location named by `io_sel` |
| mem_req | input | 1 | Memory access request |
| mem_waddr | input | 19 | CPU word address (byte address shifted right by one) |
| xl_valid | output | 1 | A translation result is present |
| xl_mapped | output | 1 | The result came through a bank entry |
| xl_page | output | 15 | Physical page number |
| xl_offset | output | 13 | Word offset inside the 16 KB page |
| range_err | output | 1 | Pulse: a bank write was refused because its entry is 28 or above |
| fb_flag | output | 1 | Pulse: a bank write to a framebuffer entry was refused |

## Verification
The translation path is driven by addresses one word either side of both window edges, the first and last word of a page, and addresses in the reserved framebuffer pages. Together these separate off-by-one errors in the window compare from errors in the entry slice or the offset slice.

Every storable entry holds a distinct value with bit 15 set. A swapped entry, a misplaced slice, or a missing 15-bit mask therefore each give a different wrong page.

The register port is tried with partial byte lanes, with index values whose ignored bits are set, and with refused entries 10, 28 and 31. After each refusal the bench reads entry 0 back. This shows whether a refused write was aliased onto a real entry.

// File: rtl/ems_pkg.sv
package ems_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_MAPPED = 2'd1,
        XS_BYPASS = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        WO_NONE  = 2'd0,
        WO_STORE = 2'd1,
        WO_RANGE = 2'd2,
        WO_RSV   = 2'd3
    } wr_outcome_e;
endpackage

// File: rtl/ems_regfile.sv
module ems_regfile
    import ems_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int BANK_W    = 16,
    parameter int IDX_W     = 8,
    parameter int ENT_W     = 5,
    parameter int PAGE_W    = 15,
    parameter int RSV_A     = 10,
    parameter int RSV_B     = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [BANK_W/8-1:0]   wr_be,
    input  logic [BANK_W-1:0]     wr_data,
    input  logic [ENT_W-1:0]      xl_entry,
    output logic [PAGE_W-1:0]     xl_page_raw,
    output logic [IDX_W-1:0]      index_q,
    output logic [BANK_W-1:0]     rd_bank,
    output logic                  range_err,
    output logic                  fb_flag
);
    localparam int LANES = BANK_W / BYTE_W;

    logic [BANK_W-1:0] bank_q [NUM_BANKS];
    logic [ENT_W-1:0]  sel_entry;
    wr_outcome_e       outcome;

    assign sel_entry = index_q[2 +: ENT_W];

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (wr_en && !wr_sel && wr_be[0])
            index_q <= wr_data[IDX_W-1:0];
    end

    // classify a bank data write
    always_comb begin
        outcome = WO_NONE;
        if (wr_en && wr_sel) begin
            if (int'(sel_entry) >= NUM_BANKS)
                outcome = WO_RANGE;
            else if (int'(sel_entry) == RSV_A || int'(sel_entry) == RSV_B)
                outcome = WO_RSV;
            else
                outcome = WO_STORE;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (outcome == WO_STORE && int'(sel_entry) == g) begin
                for (int b = 0; b < LANES; b++) begin
                    if (wr_be[b])
                        bank_q[g][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_err <= 1'b0;
            fb_flag   <= 1'b0;
        end else begin
            range_err <= (outcome == WO_RANGE);
            fb_flag   <= (outcome == WO_RSV);
        end
    end

    always_comb begin
        rd_bank = '0;
        if (int'(sel_entry) < NUM_BANKS)
            rd_bank = bank_q[sel_entry];
    end

    always_comb begin
        xl_page_raw = '0;
        if (int'(xl_entry) < NUM_BANKS)
            xl_page_raw = bank_q[xl_entry][PAGE_W-1:0];
    end
endmodule

// File: rtl/ems_xlate.sv
module ems_xlate
    import ems_pkg::*;
#(
    parameter int AW     = 19,
    parameter int ENT_W  = 5,
    parameter int OFF_W  = 13,
    parameter int PAGE_W = 15,
    parameter logic [AW-1:0] WIN_LO = 19'h40000,
    parameter logic [AW-1:0] WIN_HI = 19'h78000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic [AW-1:0]     mem_waddr,
    input  logic [PAGE_W-1:0] bank_page,
    output logic [ENT_W-1:0]  xl_entry,
    output logic              xl_valid,
    output logic              xl_mapped,
    output logic [PAGE_W-1:0] xl_page,
    output logic [OFF_W-1:0]  xl_offset
);
    xl_state_e         state_q, state_d;
    logic              in_win;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;

    assign xl_entry = mem_waddr[OFF_W +: ENT_W];
    assign in_win   = (mem_waddr >= WIN_LO) && (mem_waddr < WIN_HI);

    always_comb begin
        unique case (state_q)
            XS_IDLE, XS_MAPPED, XS_BYPASS: begin
                if (!mem_req)
                    state_d = XS_IDLE;
                else if (in_win)
                    state_d = XS_MAPPED;
                else
                    state_d = XS_BYPASS;
            end
            default: state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= XS_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (state_d == XS_MAPPED) begin
            page_q <= bank_page;
            off_q  <= mem_waddr[OFF_W-1:0];
        end else begin
            page_q <= '0;
            off_q  <= '0;
        end
    end

    always_comb begin
        xl_valid  = 1'b0;
        xl_mapped = 1'b0;
        unique case (state_q)
            XS_IDLE:   ;
            XS_MAPPED: begin xl_valid = 1'b1; xl_mapped = 1'b1; end
            XS_BYPASS: xl_valid = 1'b1;
            default:   ;
        endcase
        xl_page   = page_q;
        xl_offset = off_q;
    end
endmodule

// File: rtl/ems_bank_mapper.sv
module ems_bank_mapper
    import ems_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int BANK_W    = 16,
    parameter int IDX_W     = 8,
    parameter int AW        = 19,
    parameter int OFF_W     = 13,
    parameter int PAGE_W    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr,
    input  logic                io_sel,
    input  logic [BANK_W/8-1:0] io_be,
    input  logic [BANK_W-1:0]   io_wdata,
    output logic [BANK_W-1:0]   io_rdata,
    input  logic                mem_req,
    input  logic [AW-1:0]       mem_waddr,
    output logic                xl_valid,
    output logic                xl_mapped,
    output logic [PAGE_W-1:0]   xl_page,
    output logic [OFF_W-1:0]    xl_offset,
    output logic                range_err,
    output logic                fb_flag
);
    localparam int ENT_W = 5;

    logic [ENT_W-1:0]  xl_entry;
    logic [PAGE_W-1:0] bank_page;
    logic [IDX_W-1:0]  index_q;
    logic [BANK_W-1:0] rd_bank;

    ems_regfile #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W),
        .ENT_W(ENT_W), .PAGE_W(PAGE_W), .RSV_A(10), .RSV_B(11)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(io_wr), .wr_sel(io_sel), .wr_be(io_be), .wr_data(io_wdata),
        .xl_entry(xl_entry), .xl_page_raw(bank_page),
        .index_q(index_q), .rd_bank(rd_bank),
        .range_err(range_err), .fb_flag(fb_flag)
    );

    ems_xlate #(
        .AW(AW), .ENT_W(ENT_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W)
    ) u_xl (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_waddr(mem_waddr), .bank_page(bank_page),
        .xl_entry(xl_entry), .xl_valid(xl_valid), .xl_mapped(xl_mapped),
        .xl_page(xl_page), .xl_offset(xl_offset)
    );

    assign io_rdata = io_sel ? rd_bank : BANK_W'(index_q);
endmodule

// File: rtl/ems_bank_mapper_chk.sv
module ems_bank_mapper_chk #(
    parameter int NUM_BANKS = 28
) (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic        io_sel,
    input logic [1:0]  io_be,
    input logic [15:0] io_wdata,
    input logic [7:0]  index_q,
    input logic        mem_req,
    input logic [18:0] mem_waddr,
    input logic        xl_valid,
    input logic        xl_mapped,
    input logic [14:0] xl_page,
    input logic [12:0] xl_offset,
    input logic        range_err,
    input logic        fb_flag
);
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !io_sel && io_be[0] |=> index_q == $past(io_wdata[7:0]));

    a_r5_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_sel && int'(index_q[6:2]) >= NUM_BANKS |=> range_err);

    a_r5_range_cause: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> $past(io_wr && io_sel));

    a_r6_fb_flag: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_sel && (index_q[6:2] == 5'd10 || index_q[6:2] == 5'd11) |=> fb_flag);

    a_r6_fb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_flag && range_err));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> xl_valid);

    a_r7_offset: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_waddr >= 19'h40000 && mem_waddr < 19'h78000
        |=> xl_mapped && xl_offset == $past(mem_waddr[12:0]));

    a_r9_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid && !xl_mapped |-> xl_page == '0 && xl_offset == '0);

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> !xl_valid && !xl_mapped);
endmodule

bind ems_bank_mapper ems_bank_mapper_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel), .io_be(io_be),
    .io_wdata(io_wdata), .index_q(index_q), .mem_req(mem_req),
    .mem_waddr(mem_waddr), .xl_valid(xl_valid), .xl_mapped(xl_mapped),
    .xl_page(xl_page), .xl_offset(xl_offset),
    .range_err(range_err), .fb_flag(fb_flag)
);

// File: tb/ems_bank_mapper_tb.sv
`timescale 1ns/1ps
module ems_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_sel = 1'b0;
    logic [1:0]  io_be = 2'b00;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        mem_req = 1'b0;
    logic [18:0] mem_waddr = '0;
    logic        xl_valid, xl_mapped, range_err, fb_flag;
    logic [14:0] xl_page;
    logic [12:0] xl_offset;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mdl [32];

    localparam int NV = 11;
    localparam logic [18:0] VEC_ADDR [NV] = '{
        19'h3FFFF, 19'h40000, 19'h40001, 19'h41FFF, 19'h42000, 19'h54000,
        19'h56ABC, 19'h5A123, 19'h77FFF, 19'h78000, 19'h00000
    };

    always #2.5 clk = ~clk;

    ems_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel), .io_be(io_be),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_req(mem_req),
        .mem_waddr(mem_waddr), .xl_valid(xl_valid), .xl_mapped(xl_mapped),
        .xl_page(xl_page), .xl_offset(xl_offset),
        .range_err(range_err), .fb_flag(fb_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one I/O write; returns the flags seen the cycle after
    task automatic io_write(input logic sel, input logic [1:0] be, input logic [15:0] d,
                            output logic rerr, output logic fbf);
        io_wr = 1'b1; io_sel = sel; io_be = be; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_be = 2'b00;
        rerr = range_err; fbf = fb_flag;
    endtask

    task automatic io_read(input logic sel, output logic [15:0] d);
        io_sel = sel;
        #1;
        d = io_rdata;
    endtask

    task automatic access(input logic [18:0] a);
        mem_req = 1'b1; mem_waddr = a;
        @(negedge clk);
        mem_req = 1'b0;
    endtask

    function automatic logic [15:0] bank_val(input int e);
        return 16'h8000 | 16'((e * 16'h0123 + 16'h0011) & 16'h7FFF);
    endfunction

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic re, ff;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        io_read(1'b0, rd); check("R1 index", rd, 16'h0);
        io_read(1'b1, rd); check("R1 bank0", rd, 16'h0);
        check("R1 valid", xl_valid, 0);
        check("R1 flags", {range_err, fb_flag}, 0);

        // program all storable entries
        for (int e = 0; e < 28; e++) begin
            io_write(1'b0, 2'b01, 16'(e << 2), re, ff);
            io_write(1'b1, 2'b11, bank_val(e), re, ff);
            if (e != 10 && e != 11) mdl[e] = bank_val(e);
        end
        io_write(1'b0, 2'b01, 16'(5 << 2), re, ff);
        io_read(1'b1, rd); check("R3 readback entry5", rd, mdl[5]);

        // R7 R8 R9 vector walk
        for (int v = 0; v < NV; v++) begin
            logic [18:0] a;
            logic inwin;
            a = VEC_ADDR[v];
            inwin = (a >= 19'h40000) && (a < 19'h78000);
            access(a);
            check("R7 R9 valid", xl_valid, 1);
            check("R7 R9 mapped", xl_mapped, inwin);
            check("R7 R8 page", xl_page, inwin ? mdl[a[17:13]][14:0] : 15'h0);
            check("R7 offset", xl_offset, inwin ? a[12:0] : 13'h0);
        end
        @(negedge clk);
        check("R10 idle", xl_valid, 0);

        // R2 index ignores high byte and lane 0 disable
        io_write(1'b0, 2'b11, 16'h12A5, re, ff);
        io_read(1'b0, rd); check("R2 index", rd, 16'h00A5);
        io_write(1'b0, 2'b10, 16'h3333, re, ff);
        io_read(1'b0, rd); check("R2 be0 off", rd, 16'h00A5);

        // R3 index bit 7 and bits 1..0 ignored: 0x8F selects entry 3
        io_write(1'b0, 2'b01, 16'h008F, re, ff);
        io_read(1'b1, rd); check("R3 idx bit7", rd, mdl[3]);

        // R4 byte lanes
        io_write(1'b1, 2'b11, 16'h1234, re, ff);
        io_write(1'b1, 2'b10, 16'hAB00, re, ff);
        io_read(1'b1, rd); check("R4 hi lane", rd, 16'hAB34);
        io_write(1'b1, 2'b01, 16'hFFCD, re, ff);
        io_read(1'b1, rd); check("R4 lo lane", rd, 16'hABCD);

        // R6 framebuffer entries
        io_write(1'b0, 2'b01, 16'h0028, re, ff);
        io_write(1'b1, 2'b11, 16'h7777, re, ff);
        check("R6 flag", {ff, re}, 2'b10);
        @(negedge clk);
        check("R6 one cycle", fb_flag, 0);
        io_read(1'b1, rd); check("R6 not stored", rd, 16'h0);
        io_write(1'b0, 2'b01, 16'h002C, re, ff);
        io_write(1'b1, 2'b01, 16'h0055, re, ff);
        check("R6 entry11 flag", ff, 1);
        access(19'h57FFF);
        check("R6 page stays zero", xl_page, 15'h0);

        // R5 out-of-range entries
        io_write(1'b0, 2'b01, 16'h0070, re, ff);
        io_write(1'b1, 2'b11, 16'h5A5A, re, ff);
        check("R5 flag", {re, ff}, 2'b10);
        @(negedge clk);
        check("R5 one cycle", range_err, 0);
        io_read(1'b1, rd); check("R5 read zero", rd, 16'h0);
        io_write(1'b0, 2'b01, 16'h007C, re, ff);
        io_write(1'b1, 2'b11, 16'h6B6B, re, ff);
        check("R5 entry31 flag", re, 1);
        io_write(1'b0, 2'b01, 16'h0000, re, ff);
        io_read(1'b1, rd); check("R5 no alias entry0", rd, mdl[0]);
        access(19'h40000);
        check("R5 entry0 page", xl_page, mdl[0][14:0]);

        // R1 reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        io_write(1'b0, 2'b01, 16'h0014, re, ff);
        io_read(1'b1, rd); check("R1 cleared entry5", rd, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule